// File: doc/BRIEF.md
# Fractional Clock-Enable Divider

This block derives a slow strobe from a fast system clock. It produces a train of enable pulses, each one clock cycle wide, at a target rate. The target rate does not have to divide the input clock evenly. Downstream logic keeps running on the fast clock and advances only in cycles where the strobe is high, so no second clock domain appears.

The divide ratio is fixed when the block is elaborated. Two frequency parameters are reduced to a whole part and a 16-bit binary fraction, so the mean output rate is the input rate divided by (whole + fraction/65536). Each pulse adds the fraction to a wrap-around accumulator. When that addition carries, the interval that follows is one input cycle longer. The intervals therefore alternate between two neighbouring lengths, and their long-run average hits the requested ratio. An even ratio, such as 50 MHz down to 2 MHz (whole 25, fraction 0), gives a perfectly regular pulse train.

Top module: `frac_clk_en_div`

## Requirements
- R1: The whole part of the ratio is floor(IN_HZ / OUT_HZ). The fraction is floor((IN_HZ mod OUT_HZ) * 65536 / OUT_HZ). Both are computed at elaboration, and the whole part must be at least 2.
- R2: `clk_en` is never high in two consecutive clock cycles. Each pulse lasts exactly one input cycle.
- R3: The spacing between consecutive pulses is always either the whole part or the whole part plus one input cycle. The period jitter is therefore at most one cycle.
- R4: At every pulse a 16-bit accumulator adds the fraction modulo 65536. If that addition carries, the next interval is one cycle longer. Counting the cycle in which reset is released as cycle 0, pulse n (n = 1, 2, ...) appears in cycle n*W - 1 + floor((n-1)*F / 65536), where W is the whole part and F is the fraction.
- R5: With a zero fraction, every interval equals the whole part exactly. For example, 50 MHz to 2 MHz gives a pulse every 25 cycles.
- R6: While `rst` is high, `clk_en` stays low. The first pulse after release comes in cycle W-1, one full whole-part interval after the release cycle.
- R7: Over a long window, the number of pulses matches the count that the exact ratio predicts for that window length.
- R8: A reset applied in the middle of a run clears the interval counter and the accumulator. The sequence then restarts exactly as it does after the first reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | output | 1 | One-cycle enable strobe at the divided rate |

## Verification
`clk_en` is decoded combinationally from the interval counter and the stretch flag, and both of those are registers. The pulse is therefore valid for the whole cycle after the edge that loads the terminal count. The bench drives reset and samples the strobe on falling edges. It labels the falling edge at which reset drops as cycle 0, and compares each later cycle against the pulse position formula of R4, which it evaluates itself. Pulse counts, interval bounds and the first-pulse position are all derived from the same per-cycle record, so no check depends on when processes run at the rising edge.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

  // Whole part of the divide ratio.
  function automatic longint unsigned ratio_whole(input longint unsigned in_hz,
                                                  input longint unsigned out_hz);
    return in_hz / out_hz;
  endfunction

  // Fractional part of the ratio in units of 2**-frac_w.
  function automatic longint unsigned ratio_frac(input longint unsigned in_hz,
                                                 input longint unsigned out_hz,
                                                 input int unsigned     frac_w);
    return ((in_hz % out_hz) << frac_w) / out_hz;
  endfunction

endpackage

// File: rtl/frac_div_accum.sv
module frac_div_accum #(
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned FRAC   = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic carry,
  output logic stretch
);
  localparam logic [FRAC_W:0] FRAC_EXT = (FRAC_W+1)'(FRAC);

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum   = {1'b0, acc_q} + FRAC_EXT;
  assign carry = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      stretch <= 1'b0;
    end else if (step) begin
      acc_q   <= sum[FRAC_W-1:0];
      stretch <= carry;
    end
  end

  // The stretch flag only changes on a pulse (R4).
  assert_stretch_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(stretch));

endmodule

// File: rtl/frac_div_count.sv
module frac_div_count #(
  parameter int unsigned WHOLE = 25,
  parameter int unsigned CNT_W = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic stretch,
  output logic hit
);
  localparam logic [CNT_W-1:0] LAST_BASE = CNT_W'(WHOLE - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last = LAST_BASE + {{(CNT_W-1){1'b0}}, stretch};
  assign hit  = (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (hit) cnt_q <= '0;
    else          cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_single_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(WHOLE));

endmodule

// File: rtl/frac_clk_en_div.sv
module frac_clk_en_div
  import frac_div_pkg::*;
#(
  parameter longint unsigned IN_HZ  = 50_000_000,
  parameter longint unsigned OUT_HZ = 2_000_000,
  parameter int unsigned     FRAC_W = 16
) (
  input  logic clk,
  input  logic rst,
  output logic clk_en
);
  localparam int unsigned WHOLE = int'(ratio_whole(IN_HZ, OUT_HZ));
  localparam int unsigned FRAC  = int'(ratio_frac(IN_HZ, OUT_HZ, FRAC_W));
  localparam int unsigned CNT_W = $clog2(WHOLE + 2);

  // R1: ratios below two cannot be expressed as single-cycle strobes.
  generate
    if (WHOLE < 2) begin : g_bad_ratio
      $error("frac_clk_en_div: whole ratio must be at least 2");
    end
  endgenerate

  logic pulse;
  logic carry;
  logic stretch;

  frac_div_count #(.WHOLE(WHOLE), .CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .stretch (stretch),
    .hit     (pulse)
  );

  frac_div_accum #(.FRAC_W(FRAC_W), .FRAC(FRAC)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .step    (pulse),
    .carry   (carry),
    .stretch (stretch)
  );

  assign clk_en = pulse;

  // Interval monitor feeding the assertions below.
  logic [CNT_W-1:0] gap_q;
  logic             long_q;
  logic             first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q   <= '0;
      long_q  <= 1'b0;
      first_q <= 1'b1;
    end else if (pulse) begin
      gap_q   <= '0;
      long_q  <= carry;
      first_q <= 1'b0;
    end else begin
      gap_q   <= gap_q + CNT_W'(1);
    end
  end

  assert_interval_R3: assert property (@(posedge clk) disable iff (rst)
    pulse |-> (gap_q == CNT_W'(WHOLE - 1)) || (gap_q == CNT_W'(WHOLE)));

  assert_carry_stretch_R4: assert property (@(posedge clk) disable iff (rst)
    pulse |-> gap_q == CNT_W'(WHOLE - 1) + {{(CNT_W-1){1'b0}}, long_q});

  assert_first_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (pulse && first_q) |-> gap_q == CNT_W'(WHOLE - 1));

  assert_reset_quiet_R6: assert property (@(posedge clk)
    rst |=> !clk_en);

  generate
    if (FRAC == 0) begin : g_even
      assert_no_jitter_R5: assert property (@(posedge clk) disable iff (rst)
        pulse |-> gap_q == CNT_W'(WHOLE - 1));
    end
  endgenerate

endmodule

// File: tb/frac_clk_en_div_bench.sv
`timescale 1ns/1ps
module frac_clk_en_div_bench;

  localparam longint IN_HZ  = 50_000_000;
  localparam longint OUT_A  = 2_000_000;
  localparam longint OUT_B  = 3_000_000;
  localparam longint OUT_C  = 7_000_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_a, en_b, en_c;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #10 clk = ~clk;

  frac_clk_en_div #(.IN_HZ(IN_HZ), .OUT_HZ(OUT_A)) u_frac_clk_en_div (
    .clk(clk), .rst(rst), .clk_en(en_a));
  frac_clk_en_div #(.IN_HZ(IN_HZ), .OUT_HZ(OUT_B)) u_frac_clk_en_div_b (
    .clk(clk), .rst(rst), .clk_en(en_b));
  frac_clk_en_div #(.IN_HZ(IN_HZ), .OUT_HZ(OUT_C)) u_frac_clk_en_div_c (
    .clk(clk), .rst(rst), .clk_en(en_c));

  // Bench's own view of the ratio (R1): fraction taken from the scaled quotient.
  function automatic longint b_whole(input longint i, input longint o);
    return i / o;
  endfunction
  function automatic longint b_frac(input longint i, input longint o);
    return (i * 65536) / o - b_whole(i, o) * 65536;
  endfunction
  // R4 pulse position, pulse n counted from 1.
  function automatic longint pos(input longint n, input longint w, input longint f);
    return n * w - 1 + (((n - 1) * f) >>> 16);
  endfunction

  function automatic logic pick(input int sel);
    case (sel)
      0:       return en_a;
      1:       return en_b;
      default: return en_c;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic test_reset_state();
    int bad = 0;
    @(negedge clk) rst = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (en_a || en_b || en_c) bad++;
    end
    check(bad == 0, "R6", "strobes low during reset", bad, 0);
  endtask

  // Reset, release, then compare every cycle of a window to the R4 formula.
  task automatic scan(input int sel, input longint out_hz, input int ncyc,
                      input string tag);
    longint w = b_whole(IN_HZ, out_hz);
    longint f = b_frac(IN_HZ, out_hz);
    longint n = 1;
    longint p;
    longint exp_cnt = 0;
    int     mism = 0, first_bad = -1, got = 0, dbl = 0;
    int     last_pos = -1, first_pos = -1;
    longint min_gap = 1 << 30, max_gap = 0;
    logic   prev = 1'b0, v;
    int     quiet_bad = 0;
    @(negedge clk) rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      if (pick(sel)) quiet_bad++;
    end
    rst = 1'b0;
    p = pos(1, w, f);
    for (int j = 0; j < ncyc; j++) begin
      if (j > 0) @(negedge clk);
      v = pick(sel);
      if (v !== (j == p)) begin
        mism++;
        if (first_bad < 0) first_bad = j;
      end
      if (j == p) begin
        n++;
        p = pos(n, w, f);
      end
      if (v) begin
        got++;
        if (prev) dbl++;
        if (first_pos < 0) first_pos = j;
        if (last_pos >= 0) begin
          if (j - last_pos < min_gap) min_gap = j - last_pos;
          if (j - last_pos > max_gap) max_gap = j - last_pos;
        end
        last_pos = j;
      end
      prev = v;
    end
    for (longint k = 1; pos(k, w, f) < ncyc; k++) exp_cnt++;
    $display("scan %s: W=%0d F=%0d pulses=%0d", tag, w, f, got);
    check(quiet_bad == 0, "R6", {tag, " low during reset"}, quiet_bad, 0);
    check(first_pos == w - 1, "R6", {tag, " first pulse cycle"}, first_pos, w - 1);
    check(mism == 0, "R4", {tag, " first off-schedule cycle"}, first_bad, -1);
    check(got == exp_cnt, "R7", {tag, " pulses in window"}, got, exp_cnt);
    check(dbl == 0, "R2", {tag, " back-to-back highs"}, dbl, 0);
    check(min_gap == w, "R1", {tag, " shortest interval"}, min_gap, w);
    if (f == 0)
      check(max_gap == w, "R5", {tag, " longest interval"}, max_gap, w);
    else
      check(max_gap == w + 1, "R3", {tag, " longest interval"}, max_gap, w + 1);
  endtask

  task automatic test_integer_ratio();
    scan(0, OUT_A, 5000, "even_25");
  endtask

  task automatic test_fractional_ratio();
    scan(1, OUT_B, 6000, "frac_3M");
    scan(2, OUT_C, 4000, "frac_7M");
  endtask

  task automatic test_midrun_reset_R8();
    repeat (137) @(negedge clk);
    scan(1, OUT_B, 400, "midrun_R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    test_reset_state();
    test_integer_ratio();
    test_fractional_ratio();
    test_midrun_reset_R8();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule